// File: doc/BRIEF.md
# Level-Toggle Barrier Synchroniser

This block joins a set of nodes at a barrier without exchanging any packets. Each node holds one steady logic level. A central two-state machine watches all node levels and drives a single shared level back to every node. When every node level reads 1, the shared level goes to 1. When every node level reads 0, it returns to 0. Successive barriers therefore alternate in polarity, and no clearing step is needed between them.

On the node side, a small port runs a toggle handshake for each node. Once, just after reset, it copies the shared level as its own stored level. For each barrier, an `enter` pulse inverts the stored level and drives it out. The port then waits until the shared level equals the stored level and flags `done` for a single cycle. Node levels pass through a two-flop synchroniser before an AND tree and an OR tree of 2-input gates reduce them for the central machine.

Top module: `toggle_barrier`

## Requirements
- R1: While `rst_n` is low, the block clears `bar_level_o`, every bit of `node_level_o` and every bit of `done_o` to 0 on each clock edge.
- R2: An `enter_i` bit seen on an edge while its node is idle inverts that node's bit of `node_level_o`, and the new value is visible right after that edge.
- R3: When every node level is 1 after edge E and the shared level is 0, `bar_level_o` becomes 1 after edge E+3 and is still 0 after edge E+2.
- R4: When every node level is 0 after edge E and the shared level is 1, `bar_level_o` becomes 0 after edge E+3 and is still 1 after edge E+2.
- R5: While the node levels are a mix of 0s and 1s, `bar_level_o` does not change.
- R6: Each waiting node raises its `done_o` bit for exactly one cycle. This happens right after the first edge at which `bar_level_o` already equals its level, which is edge E+4 for the case in R3 and R4.
- R7: An `enter_i` bit seen while its node is still waiting is ignored. The node's level stays the same and no extra barrier follows from it.
- R8: No `done_o` bit rises while at least one node has not entered the current barrier.
- R9: On the first edge after reset is released, each node copies the shared level as its level, and any `enter_i` seen on that edge is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enter_i | input | NODES | Per-node request to enter the next barrier |
| done_o | output | NODES | Per-node one-cycle release pulse |
| node_level_o | output | NODES | Steady level held by each node |
| bar_level_o | output | 1 | Shared level from the central machine |

## Verification
The hardest case to reach is a barrier that is only partly entered. In that state some nodes already wait at the new polarity and others still hold the old one, so the shared level must stay put, and any repeat request from a waiting node must be dropped. The stimulus enters nodes one at a time, several cycles apart, and issues a second `enter` on a node that is already waiting. It holds there long enough for the synchroniser and the central machine to settle, and only then lets the last node enter. The same walk is then repeated at the falling polarity.

// File: rtl/toggle_barrier_pkg.sv
// Package: shared state encodings for the level-toggle barrier.
// Assumes a single clock domain for the node ports and the central machine.
package toggle_barrier_pkg;

    // Central machine states: shared level 0 or shared level 1
    typedef enum logic {
        CM_LOW  = 1'b0,
        CM_HIGH = 1'b1
    } central_state_e;

    // Node port states
    typedef enum logic [1:0] {
        NP_INIT = 2'd0,
        NP_IDLE = 2'd1,
        NP_WAIT = 2'd2
    } node_state_e;

endpackage

// File: rtl/level_sync.sv
// Module: two-flop synchroniser for a vector of steady levels.
// Assumes the inputs are levels held for many cycles, not pulses.
module level_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Two-stage capture, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/gate_tree.sv
// Module: balanced tree of 2-input AND or OR gates.
// Depth is ceil(log2(WIDTH)). Unused leaves are padded with the identity value.
// Assumes WIDTH >= 2.
module gate_tree #(
    parameter int WIDTH  = 4,
    parameter bit USE_AND = 1'b1
) (
    input  logic [WIDTH-1:0] d_i,
    output logic             y_o
);

    localparam int DEPTH  = $clog2(WIDTH);
    localparam int LEAVES = 1 << DEPTH;
    localparam logic PAD  = USE_AND;

    // Heap layout: index 1 is the root, leaves sit at LEAVES..2*LEAVES-1
    logic [2*LEAVES-1:1] node_w;

    genvar gi;
    generate
        for (gi = 0; gi < LEAVES; gi++) begin : g_leaf
            if (gi < WIDTH) begin : g_real
                assign node_w[LEAVES+gi] = d_i[gi];
            end else begin : g_pad
                assign node_w[LEAVES+gi] = PAD;
            end
        end
        for (gi = 1; gi < LEAVES; gi++) begin : g_inner
            if (USE_AND) begin : g_and
                assign node_w[gi] = node_w[2*gi] & node_w[2*gi+1];
            end else begin : g_or
                assign node_w[gi] = node_w[2*gi] | node_w[2*gi+1];
            end
        end
    endgenerate

    assign y_o = node_w[1];

endmodule

// File: rtl/central_fsm.sv
// Module: two-state machine that drives the shared barrier level.
// It goes from low to high when all node levels are 1, and from high to low
// when all are 0. Assumes the reduced inputs are already synchronised.
module central_fsm
    import toggle_barrier_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic all_high_i,
    input  logic any_high_i,
    output logic level_o
);

    central_state_e state_q;
    central_state_e state_d;

    // Next-state choice from the reduced node levels
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CM_LOW:  if (all_high_i)  state_d = CM_HIGH;
            CM_HIGH: if (!any_high_i) state_d = CM_LOW;
            default: state_d = CM_LOW;
        endcase
    end

    // State register, starting at the low level
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CM_LOW;
        else        state_q <= state_d;
    end

    assign level_o = (state_q == CM_HIGH);

endmodule

// File: rtl/node_port.sv
// Module: node-side toggle handshake for one node.
// It samples the shared level once after reset, toggles on enter, waits for
// the shared level to match, then pulses done. Assumes the shared level is
// in the same clock domain.
module node_port
    import toggle_barrier_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enter_i,
    input  logic shared_i,
    output logic level_o,
    output logic done_o,
    output logic waiting_o
);

    node_state_e state_q;
    logic        level_q;
    logic        done_q;

    // Handshake sequencing: init read, toggle on enter, release on match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NP_INIT;
            level_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                NP_INIT: begin
                    level_q <= shared_i;
                    state_q <= NP_IDLE;
                end
                NP_IDLE: begin
                    if (enter_i) begin
                        level_q <= ~level_q;
                        state_q <= NP_WAIT;
                    end
                end
                NP_WAIT: begin
                    if (shared_i == level_q) begin
                        done_q  <= 1'b1;
                        state_q <= NP_IDLE;
                    end
                end
                default: state_q <= NP_IDLE;
            endcase
        end
    end

    assign level_o   = level_q;
    assign done_o    = done_q;
    assign waiting_o = (state_q == NP_WAIT);

endmodule

// File: rtl/toggle_barrier.sv
// Module: top of the level-toggle barrier for NODES nodes.
// Node levels are synchronised, reduced by AND and OR trees, and feed the
// central machine. Its shared level goes back to every node port.
// Assumes NODES >= 2.
module toggle_barrier #(
    parameter int NODES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NODES-1:0] enter_i,
    output logic [NODES-1:0] done_o,
    output logic [NODES-1:0] node_level_o,
    output logic             bar_level_o
);

    logic [NODES-1:0] level_w;
    logic [NODES-1:0] level_sync_w;
    logic [NODES-1:0] node_wait;
    logic             all_high_w;
    logic             any_high_w;
    logic             shared_w;

    genvar ni;
    generate
        for (ni = 0; ni < NODES; ni++) begin : g_node
            node_port u_port (
                .clk      (clk),
                .rst_n    (rst_n),
                .enter_i  (enter_i[ni]),
                .shared_i (shared_w),
                .level_o  (level_w[ni]),
                .done_o   (done_o[ni]),
                .waiting_o(node_wait[ni])
            );
        end
    endgenerate

    level_sync #(.WIDTH(NODES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (level_w),
        .q_o  (level_sync_w)
    );

    gate_tree #(.WIDTH(NODES), .USE_AND(1'b1)) u_and_tree (
        .d_i(level_sync_w),
        .y_o(all_high_w)
    );

    gate_tree #(.WIDTH(NODES), .USE_AND(1'b0)) u_or_tree (
        .d_i(level_sync_w),
        .y_o(any_high_w)
    );

    central_fsm u_central (
        .clk       (clk),
        .rst_n     (rst_n),
        .all_high_i(all_high_w),
        .any_high_i(any_high_w),
        .level_o   (shared_w)
    );

    assign node_level_o = level_w;
    assign bar_level_o  = shared_w;

endmodule

// File: rtl/toggle_barrier_checker.sv
// Module: property checker for the level-toggle barrier, bound to the top.
// Assumes the three-register path from node level to shared level.
module toggle_barrier_checker #(
    parameter int NODES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NODES-1:0] done_o,
    input  logic [NODES-1:0] node_level_o,
    input  logic             bar_level_o,
    input  logic [NODES-1:0] node_wait
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (bar_level_o == 1'b0 && node_level_o == '0 && done_o == '0)); // R1

    AST_RISE_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bar_level_o) |-> ($past(node_level_o, 3) == {NODES{1'b1}})); // R3

    AST_FALL_NEEDS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bar_level_o) |-> ($past(node_level_o, 3) == '0)); // R4

    AST_MIXED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(node_level_o, 3) != '0 && $past(node_level_o, 3) != {NODES{1'b1}})
        |-> $stable(bar_level_o)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o & $past(done_o)) == '0); // R6

    AST_DONE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        ((node_level_o ^ {NODES{bar_level_o}}) & done_o) == '0); // R6

    AST_WAIT_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ((node_level_o ^ $past(node_level_o)) & $past(node_wait)) == '0); // R7

endmodule

bind toggle_barrier toggle_barrier_checker #(.NODES(NODES)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_o      (done_o),
    .node_level_o(node_level_o),
    .bar_level_o (bar_level_o),
    .node_wait   (node_wait)
);

// File: tb/toggle_barrier_tb_top.sv
// Bench: scoreboard for the level-toggle barrier. A driver task keeps a
// model of the levels and pushes the expected done pulses into a queue,
// and a monitor compares them on every cycle.
module toggle_barrier_tb_top;

    localparam int N = 4;

    typedef struct {
        int           cyc;
        logic [N-1:0] mask;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] enter = '0;
    logic [N-1:0] done;
    logic [N-1:0] node_level;
    logic         bar_level;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t exp_q[$];

    logic [N-1:0] lvl_m = '0;
    logic [N-1:0] wait_m = '0;
    logic         out_m = 1'b0;

    toggle_barrier #(.NODES(N)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_i     (enter),
        .done_o      (done),
        .node_level_o(node_level),
        .bar_level_o (bar_level)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // Monitor: compare done against the scoreboard queue on every cycle
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                logic [N-1:0] expd;
                expd = '0;
                if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                    expd = exp_q[0].mask;
                    void'(exp_q.pop_front());
                end
                if (expd != '0 || done != '0)
                    check(done == expd, "R6/R8 done", int'(done), int'(expd));
            end
        end
    end

    // Driver: one-cycle enter pulse; update the model and push expectations
    task automatic pulse(input logic [N-1:0] mask);
        int  e;
        bit  flip;
        @(negedge clk);
        enter = mask;
        @(negedge clk);
        enter = '0;
        e = cyc;
        for (int i = 0; i < N; i++) begin
            if (mask[i] && !wait_m[i]) begin
                lvl_m[i]  = ~lvl_m[i];
                wait_m[i] = 1'b1;
            end
        end
        check(node_level == lvl_m, "R2/R7 level after enter", int'(node_level), int'(lvl_m));
        flip = (lvl_m == {N{~out_m}});
        if (flip) begin
            exp_q.push_back('{cyc: e + 4, mask: wait_m});
            wait_m = '0;
            @(negedge clk);
            @(negedge clk);
            check(bar_level == out_m, out_m ? "R4 held at E+2" : "R3 held at E+2",
                  int'(bar_level), int'(out_m));
            out_m = ~out_m;
            @(negedge clk);
            check(bar_level == out_m, out_m ? "R3 rise at E+3" : "R4 fall at E+3",
                  int'(bar_level), int'(out_m));
            repeat (4) @(negedge clk);
        end else begin
            repeat (6) @(negedge clk);
            check(bar_level == out_m, "R5 shared level holds while mixed",
                  int'(bar_level), int'(out_m));
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        enter = {N{1'b1}};
        repeat (3) @(negedge clk);
        check(bar_level == 1'b0, "R1 shared level in reset", int'(bar_level), 0);
        check(node_level == '0, "R1 node levels in reset", int'(node_level), 0);
        check(done == '0, "R1 done in reset", int'(done), 0);
        // R9: enter held over the first edge after release is ignored
        rst_n = 1'b1;
        @(negedge clk);
        enter = '0;
        check(node_level == '0, "R9 enter ignored at init", int'(node_level), 0);
        repeat (3) @(negedge clk);
        check(bar_level == 1'b0, "R9 no barrier after init", int'(bar_level), 0);

        // Rising barrier entered one node at a time (R5, R8)
        pulse(4'b0001);
        pulse(4'b0010);
        pulse(4'b0001); // R7: node 0 already waiting
        pulse(4'b0100);
        pulse(4'b1000); // completes: R3, R6

        // Falling barrier, all at once (R4, R6)
        pulse(4'b1111);

        // Rising barrier in two halves, with a repeat on a waiting node
        pulse(4'b0011);
        pulse(4'b0010); // R7
        pulse(4'b1100); // R3

        // Falling barrier, staggered
        pulse(4'b1000);
        pulse(4'b0111); // R4

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6 every expected done seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule